// File: doc/BRIEF.md
# Serial 16-bit PRESENT-128 Encryptor

This block encrypts one 64-bit block under a 128-bit key with the PRESENT cipher. It runs 31 rounds and then a final round-key XOR. The datapath is 16 bits wide, so each round takes eight clocks.

In the first four clocks of a round, the top 16 bits of the state register are XORed with the matching 16 bits of the round key and passed through four 4-bit S-boxes. The results are shifted into a second register as four 4-bit lanes, which performs the bit permutation. In the last four clocks that register drains back into the state register 16 bits at a time, and the key register completes its per-round update.

A caller presents the plaintext and key, then pulses `start` while the block is idle. Both inputs are captured on that clock and may change freely afterwards. A `start` raised while an operation is running is dropped. There is no back-pressure: `done` pulses for one clock when the result is ready, and `ciphertext` keeps that result until the next accepted start. A new start may be given in the same clock that `done` is high.

Top module: `present16_enc`

## Requirements
- R1: `ciphertext` equals the PRESENT encryption of the captured plaintext under the captured 128-bit key. Each of the 31 rounds XORs the state with the upper 64 key bits, substitutes every nibble, and permutes the bits. The final XOR uses the key produced after round 31.
- R2: `done` goes high exactly 252 clocks (8 per round times 31, plus 4) after the clock edge that accepted `start`, and stays high for exactly one clock.
- R3: A `start` seen while an operation is in progress, including during the final XOR clocks, is ignored. Changes to `plaintext` or `key` after acceptance are also ignored. Neither alters the running result or its timing.
- R4: After reset, `done` is 0 and `ciphertext` is all zeros.
- R5: While idle with `start` low, `ciphertext` holds its last value whatever `plaintext` and `key` do.
- R6: A `start` given in the clock where `done` is high is accepted, so operations can run back to back.
- R7: Key update after round i (i = 1..31):
  - rotate the 128-bit key left by 61;
  - substitute the two top nibbles (bits 127:124 and 123:120);
  - XOR the 5-bit value i into bits 66:62.
- R8: The substitution maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. The permutation moves bit j to bit 16*j mod 63 for j < 63, and keeps bit 63 in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an encryption; accepted only while idle |
| plaintext | input | 64 | Block to encrypt, captured on accepted start |
| key | input | 128 | Cipher key, captured on accepted start |
| ciphertext | output | 64 | Result; valid from the done pulse until the next accepted start |
| done | output | 1 | One-clock pulse when the result is ready |

## Verification
The bench uses three directed vectors:
- all-zero plaintext and key, so every key bit after round 1 comes from the S-box and round-counter terms;
- all-ones plaintext and key, which drives the substitution with input F and exposes lane-order mistakes in the permutation;
- a single set plaintext bit, which makes any misrouted permutation bit visible.

Around twenty random plaintext/key pairs, run back to back, separate slice-ordering and key-rotation faults that the directed vectors could mask. One run injects start pulses mid-round and during the final XOR, and scrambles the input buses after capture, to show that a running operation keeps its result and its 252-clock latency.

// File: rtl/present16_pkg.sv
package present16_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_RUN  = 2'd1,
    CTL_FIN  = 2'd2
  } ctl_t;

  function automatic logic [3:0] sub_nib(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
      4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
      4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
      4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/present16_sbox.sv
module present16_sbox (
  input  logic [3:0] din,
  output logic [3:0] dout
);
  import present16_pkg::*;
  always_comb dout = sub_nib(din);
endmodule

// File: rtl/present16_state_path.sv
module present16_state_path #(
  parameter int BLK_W   = 64,
  parameter int SLICE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BLK_W-1:0]   pt_in,
  input  logic [SLICE_W-1:0] rk_slice,
  input  logic               sub_en,
  input  logic               copy_en,
  input  logic               white_en,
  output logic [BLK_W-1:0]   state
);
  localparam int NIB  = SLICE_W / 4;
  localparam int LANE = BLK_W / 4;

  logic [BLK_W-1:0]   sr1_q, sr2_q;
  logic [SLICE_W-1:0] mix, sb;

  assign mix = sr1_q[BLK_W-1 -: SLICE_W] ^ rk_slice;

  for (genvar k = 0; k < NIB; k++) begin : g_sbox
    present16_sbox u_sb (.din(mix[4*k +: 4]), .dout(sb[4*k +: 4]));
  end

  // Lane b collects bit b of every S-box output; S-box k supplies nibble bit k.
  logic [BLK_W-1:0] sr2_shift;
  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [3:0] nib_in;
    for (genvar k = 0; k < NIB; k++) begin : g_bit
      assign nib_in[k] = sb[4*k + b];
    end
    assign sr2_shift[LANE*b +: LANE] = {sr2_q[LANE*b +: LANE-4], nib_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr1_q <= '0;
      sr2_q <= '0;
    end else if (load) begin
      sr1_q <= pt_in;
    end else if (sub_en) begin
      sr1_q <= {sr1_q[BLK_W-SLICE_W-1:0], sr1_q[BLK_W-1 -: SLICE_W]};
      sr2_q <= sr2_shift;
    end else if (copy_en) begin
      sr1_q <= {sr1_q[BLK_W-SLICE_W-1:0], sr2_q[BLK_W-1 -: SLICE_W]};
      sr2_q <= {sr2_q[BLK_W-SLICE_W-1:0], {SLICE_W{1'b0}}};
    end else if (white_en) begin
      sr1_q <= {sr1_q[BLK_W-SLICE_W-1:0], mix};
    end
  end

  assign state = sr1_q;

  // R1: copy-back moves the permutation register's top slice into the state.
  a_r1_copy_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_en && !load) |=> sr1_q[SLICE_W-1:0] == $past(sr2_q[BLK_W-1 -: SLICE_W]));

  // R1: during substitution the state only rotates, keeping every bit.
  a_r1_sub_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en && !load) |=> $countones(sr1_q) == $countones($past(sr1_q)));
endmodule

// File: rtl/present16_key_path.sv
module present16_key_path #(
  parameter int KEY_W   = 128,
  parameter int SLICE_W = 16,
  parameter int RC_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [KEY_W-1:0]   key_in,
  input  logic               rot_en,
  input  logic               upd_en,
  input  logic [RC_W-1:0]    rnd,
  output logic [SLICE_W-1:0] rk_slice
);
  localparam int BACK = 3;   // 64 rotated minus 61 required
  localparam int CLO  = 62;  // low bit of the counter field

  logic [KEY_W-1:0] key_q, back_rot, upd;
  logic [7:0]       top_sub;

  assign back_rot = {key_q[BACK-1:0], key_q[KEY_W-1:BACK]};

  for (genvar s = 0; s < 2; s++) begin : g_ksbox
    present16_sbox u_ksb (.din(back_rot[KEY_W-8+4*s +: 4]), .dout(top_sub[4*s +: 4]));
  end

  always_comb begin
    upd = back_rot;
    upd[KEY_W-1 -: 8] = top_sub;
    upd[CLO +: RC_W]  = back_rot[CLO +: RC_W] ^ rnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key_q <= '0;
    else if (load)    key_q <= key_in;
    else if (rot_en)  key_q <= {key_q[KEY_W-SLICE_W-1:0], key_q[KEY_W-1 -: SLICE_W]};
    else if (upd_en)  key_q <= upd;
  end

  assign rk_slice = key_q[KEY_W-1 -: SLICE_W];

  // R7: the 16-bit rotation brings the next key slice to the tap.
  a_r7_key_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_en && !load) |=> rk_slice == $past(key_q[KEY_W-SLICE_W-1 -: SLICE_W]));

  // R7: counter field after update equals the back-rotated bits XOR the round number.
  a_r7_counter_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !rot_en && !load) |=>
      key_q[CLO +: RC_W] == ($past(key_q[CLO+BACK +: RC_W]) ^ $past(rnd)));
endmodule

// File: rtl/present16_enc.sv
module present16_enc #(
  parameter int ROUNDS = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [63:0]  plaintext,
  input  logic [127:0] key,
  output logic [63:0]  ciphertext,
  output logic         done
);
  import present16_pkg::*;

  localparam int BLK_W   = 64;
  localparam int KEY_W   = 128;
  localparam int SLICE_W = 16;
  localparam int SLICES  = BLK_W / SLICE_W;
  localparam int PH_W    = $clog2(2 * SLICES);
  localparam int RC_W    = 5;

  ctl_t             ctl_q;
  logic [PH_W-1:0]  phase_q;
  logic [RC_W-1:0]  rnd_q;
  logic             done_q;

  logic load, sub_en, copy_en, white_en, rot_en, upd_en, busy;
  logic [SLICE_W-1:0] rk_slice;

  assign busy     = (ctl_q != CTL_IDLE);
  assign load     = (ctl_q == CTL_IDLE) && start;
  assign sub_en   = (ctl_q == CTL_RUN) && (phase_q <  PH_W'(SLICES));
  assign copy_en  = (ctl_q == CTL_RUN) && (phase_q >= PH_W'(SLICES));
  assign white_en = (ctl_q == CTL_FIN);
  assign rot_en   = sub_en || white_en;
  assign upd_en   = (ctl_q == CTL_RUN) && (phase_q == PH_W'(SLICES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= CTL_IDLE;
      phase_q <= '0;
      rnd_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ctl_q)
        CTL_IDLE: if (start) begin
          ctl_q   <= CTL_RUN;
          phase_q <= '0;
          rnd_q   <= RC_W'(1);
        end
        CTL_RUN: begin
          phase_q <= phase_q + 1'b1;
          if (phase_q == PH_W'(2 * SLICES - 1)) begin
            phase_q <= '0;
            if (rnd_q == RC_W'(ROUNDS)) ctl_q <= CTL_FIN;
            else                        rnd_q <= rnd_q + 1'b1;
          end
        end
        CTL_FIN: begin
          phase_q <= phase_q + 1'b1;
          if (phase_q == PH_W'(SLICES - 1)) begin
            ctl_q   <= CTL_IDLE;
            phase_q <= '0;
            done_q  <= 1'b1;
          end
        end
        default: ctl_q <= CTL_IDLE;
      endcase
    end
  end

  present16_state_path #(.BLK_W(BLK_W), .SLICE_W(SLICE_W)) u_state (
    .clk(clk), .rst_n(rst_n), .load(load), .pt_in(plaintext),
    .rk_slice(rk_slice), .sub_en(sub_en), .copy_en(copy_en),
    .white_en(white_en), .state(ciphertext)
  );

  present16_key_path #(.KEY_W(KEY_W), .SLICE_W(SLICE_W), .RC_W(RC_W)) u_key (
    .clk(clk), .rst_n(rst_n), .load(load), .key_in(key),
    .rot_en(rot_en), .upd_en(upd_en), .rnd(rnd_q), .rk_slice(rk_slice)
  );

  assign done = done_q;

  // R2: done lasts one clock.
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: done only follows the last whitening clock.
  a_r2_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ctl_q == CTL_FIN && phase_q == PH_W'(SLICES - 1)));

  // R3: a start while busy leaves the round number untouched mid-round.
  a_r3_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == CTL_RUN && phase_q != PH_W'(2 * SLICES - 1) && start) |=> $stable(rnd_q));

  // R5: idle without start keeps the result.
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ciphertext));

  // R7: the round number stays within 1..ROUNDS while busy.
  a_r7_rnd_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rnd_q >= RC_W'(1) && rnd_q <= RC_W'(ROUNDS)));
endmodule

// File: tb/present16_enc_bench.sv
module present16_enc_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [63:0]  plaintext;
  logic [127:0] key;
  logic [63:0]  ciphertext;
  logic         done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  localparam int LAT = 252;

  always #10 clk = ~clk;  // 50 MHz

  present16_enc u_present16_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
    .key(key), .ciphertext(ciphertext), .done(done)
  );

  function automatic logic [3:0] m_sb(input logic [3:0] x);
    logic [63:0] t = 64'h21748FE3DA09B65C;  // entry x at nibble x
    return t[4*x +: 4];
  endfunction

  function automatic logic [63:0] m_enc(input logic [63:0] p, input logic [127:0] k);
    logic [63:0]  s = p;
    logic [63:0]  o;
    logic [127:0] kk = k;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ kk[127:64];
      for (int n = 0; n < 16; n++) s[4*n +: 4] = m_sb(s[4*n +: 4]);
      o = '0;
      for (int j = 0; j < 63; j++) o[(16*j) % 63] = s[j];
      o[63] = s[63];
      s = o;
      kk = {kk[66:0], kk[127:67]};
      kk[127:124] = m_sb(kk[127:124]);
      kk[123:120] = m_sb(kk[123:120]);
      kk[66:62]   = kk[66:62] ^ 5'(r);
    end
    return s ^ kk[127:64];
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] p, input logic [127:0] k, input bit inject, input string req);
    logic [63:0] exp = m_enc(p, k);
    int n = 0;
    bit got = 0;
    plaintext = p; key = k; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    plaintext = {$urandom, $urandom};
    key = {$urandom, $urandom, $urandom, $urandom};
    check(done == 1'b0, "R2 done low after pulse", 128'(done), 128'(0));
    while (!got && n < 400) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (inject && (n == 60 || n == 251)) begin
        start = 1'b1;
        plaintext = {$urandom, $urandom};
      end else start = 1'b0;
      if (done) got = 1;
    end
    check(got && n == LAT, {req, " latency"}, 128'(n), 128'(LAT));
    check(ciphertext == exp, {req, " ciphertext"}, 128'(ciphertext), 128'(exp));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start = 1'b0; plaintext = '0; key = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R4 done after reset", 128'(done), 128'(0));
    check(ciphertext == 64'h0, "R4 ciphertext after reset", 128'(ciphertext), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    run_op(64'h0, 128'h0, 1'b0, "R7 zero key");
    run_op('1, '1, 1'b0, "R8 all ones");
    run_op(64'h1, 128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0, "R8 single bit");
    run_op({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 1'b1, "R3 busy start");

    // R5: idle hold with moving inputs
    held = ciphertext;
    for (int i = 0; i < 10; i++) begin
      plaintext = {$urandom, $urandom};
      key = {$urandom, $urandom, $urandom, $urandom};
      @(posedge clk); @(negedge clk);
    end
    check(ciphertext == held, "R5 idle hold", 128'(ciphertext), 128'(held));

    // R1 / R6: random vectors, each started in the clock done is high
    for (int v = 0; v < 20; v++)
      run_op({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 1'b0, "R1 R6 random");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule